// File: doc/BRIEF.md
# Packed word dot-product accumulator

This block is a SIMD multiply-accumulate datapath. Each 32-bit output lane takes one accumulator value and two adjacent pairs of 16-bit words, one pair from each source vector. It multiplies the pairs element by element and adds both products to the accumulator. A 3-bit mode input sets how each operand is extended before the multiply: signed-by-unsigned, unsigned-by-signed or unsigned-by-unsigned. The same input sets whether the lane sum wraps or saturates.

The number of lanes is fixed by a parameter. A run-time `wide` input picks either the full vector or only its lower half. When only the lower half is active, the upper result lanes read as zero. Results are registered: a request with `in_valid` high gives a packed result one clock later, with `out_valid` high alongside it.

Top module: `dpw_accum`

## Requirements
- R1: Output lane j is formed only from accumulator lane j (bits 32j+31:32j) and from words 2j and 2j+1 of each source (word k at bits 16k+15:16k). Word 2j of the first source multiplies word 2j of the second source, and word 2j+1 multiplies word 2j+1.
- R2: mode[1:0]=00 sign-extends the first-source words, zero-extends the second-source words and treats the accumulator as signed.
- R3: mode[1:0]=01 zero-extends the first-source words, sign-extends the second-source words and treats the accumulator as signed.
- R4: mode[1:0]=10 zero-extends all words and treats the accumulator as unsigned.
- R5: With mode[2]=0 the lane result is the low 32 bits of accumulator plus both products, so it wraps modulo 2^32.
- R6: With mode[2]=1 and mode[1:0] equal to 00 or 01, the exact lane sum is clamped to the range 0x80000000..0x7FFFFFFF, read as signed.
- R7: With mode=110 the exact lane sum is clamped to 0xFFFFFFFF, so a lane result is never below its unsigned accumulator.
- R8: With wide=0, result lanes LANES/2 and above are zero.
- R9: mode[1:0]=11 gives an all-zero result whatever mode[2] is.
- R10: A request sampled with in_valid=1 appears on result one clock later, with out_valid=1. A clock with in_valid=0 leaves out_valid=0 one clock later and leaves result unchanged.
- R11: An active-low rst_n clears out_valid at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe; loads the result register |
| wide | input | 1 | 1: all lanes active; 0: lower half only |
| mode | input | 3 | [2] saturate, [1:0] signedness pair |
| acc_in | input | LANES*32 | Packed 32-bit accumulators |
| src_a | input | LANES*32 | First source, packed 16-bit words |
| src_b | input | LANES*32 | Second source, packed 16-bit words |
| out_valid | output | 1 | Result valid |
| result | output | LANES*32 | Packed 32-bit lane results |

## Verification
The bound checker tests the following on every clock:
- out_valid tracks in_valid with one clock of delay.
- result holds across an idle clock.
- The upper half of result is zero after a narrow request.
- result is all zero after an unused-mode request.
- No lane falls below its accumulator in unsigned saturating mode.

Only the bench's sweeps can show that each signedness pair and clamp gives the exact value. The sweeps cover every mode and both widths, with words 0x0000, 0x0001, 0x7FFF, 0x8000, 0xFFFF and 0x1234 and accumulators at and near both 32-bit limits. The bench also checks lane isolation with distinct per-lane values, and checks that the reset acts without a clock.

// File: rtl/dpw_pkg.sv
package dpw_pkg;
  localparam int WORD_W = 16;
  localparam int ACC_W  = 32;
  localparam int PROD_W = 2 * WORD_W + 2;
  localparam int SUM_W  = ACC_W + 4;

  typedef enum logic [1:0] {
    PAIR_SU   = 2'b00,
    PAIR_US   = 2'b01,
    PAIR_UU   = 2'b10,
    PAIR_NONE = 2'b11
  } pair_e;

  typedef struct packed {
    logic a_sg;
    logic b_sg;
    logic acc_sg;
    logic ok;
  } sign_cfg_t;

  function automatic sign_cfg_t decode_pair(input pair_e p);
    sign_cfg_t c;
    c = '0;
    case (p)
      PAIR_SU: c = '{a_sg: 1'b1, b_sg: 1'b0, acc_sg: 1'b1, ok: 1'b1};
      PAIR_US: c = '{a_sg: 1'b0, b_sg: 1'b1, acc_sg: 1'b1, ok: 1'b1};
      PAIR_UU: c = '{a_sg: 1'b0, b_sg: 1'b0, acc_sg: 1'b0, ok: 1'b1};
      default: c = '0;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/dpw_lane.sv
module dpw_lane
  import dpw_pkg::*;
(
  input  logic [WORD_W-1:0]       a0,
  input  logic [WORD_W-1:0]       a1,
  input  logic [WORD_W-1:0]       b0,
  input  logic [WORD_W-1:0]       b1,
  input  logic [ACC_W-1:0]        acc,
  input  logic                    a_sg,
  input  logic                    b_sg,
  input  logic                    acc_sg,
  output logic signed [SUM_W-1:0] sum
);
  logic signed [WORD_W:0]    ax0, ax1, bx0, bx1;
  logic signed [PROD_W-1:0]  p0, p1;
  logic signed [SUM_W-1:0]   accx;

  // one extra bit per word carries sign or zero extension
  assign ax0 = {a_sg & a0[WORD_W-1], a0};
  assign ax1 = {a_sg & a1[WORD_W-1], a1};
  assign bx0 = {b_sg & b0[WORD_W-1], b0};
  assign bx1 = {b_sg & b1[WORD_W-1], b1};

  assign p0 = ax0 * bx0;
  assign p1 = ax1 * bx1;

  assign accx = {{(SUM_W-ACC_W){acc_sg & acc[ACC_W-1]}}, acc};
  assign sum  = accx + SUM_W'(p0) + SUM_W'(p1);
endmodule

// File: rtl/dpw_clamp.sv
module dpw_clamp
  import dpw_pkg::*;
(
  input  logic signed [SUM_W-1:0] sum,
  input  logic                    sat,
  input  logic                    uns,
  output logic [ACC_W-1:0]        y
);
  logic [SUM_W-ACC_W:0] head;

  assign head = sum[SUM_W-1:ACC_W-1];

  always_comb begin
    y = sum[ACC_W-1:0];
    if (sat) begin
      if (uns) begin
        if (|sum[SUM_W-1:ACC_W]) y = '1;
      end else if (!(&head) && (|head)) begin
        y = sum[SUM_W-1] ? {1'b1, {(ACC_W-1){1'b0}}} : {1'b0, {(ACC_W-1){1'b1}}};
      end
    end
  end
endmodule

// File: rtl/dpw_accum.sv
module dpw_accum
  import dpw_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic                   wide,
  input  logic [2:0]             mode,
  input  logic [LANES*ACC_W-1:0] acc_in,
  input  logic [LANES*ACC_W-1:0] src_a,
  input  logic [LANES*ACC_W-1:0] src_b,
  output logic                   out_valid,
  output logic [LANES*ACC_W-1:0] result
);
  localparam int VEC_W = LANES * ACC_W;
  localparam int HALF  = LANES / 2;

  sign_cfg_t        cfg;
  logic             sat;
  logic [VEC_W-1:0] result_d, result_q;
  logic             valid_d, valid_q;

  assign cfg = decode_pair(pair_e'(mode[1:0]));
  assign sat = mode[2];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam bit UPPER = (g >= HALF);
    logic signed [SUM_W-1:0] sum;
    logic [ACC_W-1:0]        y;

    dpw_lane u_lane (
      .a0     (src_a[(2*g)*WORD_W +: WORD_W]),
      .a1     (src_a[(2*g+1)*WORD_W +: WORD_W]),
      .b0     (src_b[(2*g)*WORD_W +: WORD_W]),
      .b1     (src_b[(2*g+1)*WORD_W +: WORD_W]),
      .acc    (acc_in[g*ACC_W +: ACC_W]),
      .a_sg   (cfg.a_sg),
      .b_sg   (cfg.b_sg),
      .acc_sg (cfg.acc_sg),
      .sum    (sum)
    );

    dpw_clamp u_clamp (
      .sum (sum),
      .sat (sat),
      .uns (!cfg.acc_sg),
      .y   (y)
    );

    assign result_d[g*ACC_W +: ACC_W] =
      (cfg.ok && (wide || !UPPER)) ? y : '0;
  end

  assign valid_d = in_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (in_valid) result_q <= result_d;
  end

  assign out_valid = valid_q;
  assign result    = result_q;
endmodule

// File: rtl/dpw_accum_chk.sv
module dpw_accum_chk #(
  parameter int LANES = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                wide,
  input logic [2:0]          mode,
  input logic [LANES*32-1:0] acc_in,
  input logic                out_valid,
  input logic [LANES*32-1:0] result
);
  localparam int VEC_W = LANES * 32;
  localparam int HALF  = LANES / 2;

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R10
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R10
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && out_valid) |=> $stable(result)); // R10
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !wide) |=> (result[VEC_W-1:HALF*32] == '0)); // R8
  AST_UNUSED_MODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode[1:0] == 2'b11) |=> (result == '0)); // R9

  for (genvar g = 0; g < LANES; g++) begin : g_uns
    AST_UNS_SAT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && wide && mode == 3'b110) |=>
      (result[g*32 +: 32] >= $past(acc_in[g*32 +: 32]))); // R7
  end
endmodule

bind dpw_accum dpw_accum_chk #(.LANES(LANES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .wide      (wide),
  .mode      (mode),
  .acc_in    (acc_in),
  .out_valid (out_valid),
  .result    (result)
);

// File: tb/dpw_accum_test.sv
`timescale 1ns/1ps
module dpw_accum_test;
  localparam int LANES = 8;
  localparam int W     = LANES * 32;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic         wide;
  logic [2:0]   mode;
  logic [W-1:0] acc_in, src_a, src_b;
  logic         out_valid;
  logic [W-1:0] result;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  dpw_accum #(.LANES(LANES)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .wide(wide), .mode(mode),
    .acc_in(acc_in), .src_a(src_a), .src_b(src_b),
    .out_valid(out_valid), .result(result)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic longint lane_sum(input logic [2:0] md, input logic [31:0] acc,
                                      input logic [15:0] a0, input logic [15:0] a1,
                                      input logic [15:0] b0, input logic [15:0] b1);
    bit sa, sb;
    longint av0, av1, bv0, bv1, accv;
    sa = (md[1:0] == 2'b00);
    sb = (md[1:0] == 2'b01);
    av0 = sa ? longint'($signed(a0)) : longint'(a0);
    av1 = sa ? longint'($signed(a1)) : longint'(a1);
    bv0 = sb ? longint'($signed(b0)) : longint'(b0);
    bv1 = sb ? longint'($signed(b1)) : longint'(b1);
    accv = (md[1:0] == 2'b10) ? longint'(acc) : longint'($signed(acc));
    return accv + av0 * bv0 + av1 * bv1;
  endfunction

  function automatic logic [31:0] lane_ref(input logic [2:0] md, input longint s);
    longint smax, smin, umax;
    smax = (longint'(1) <<< 31) - 1;
    smin = -(longint'(1) <<< 31);
    umax = (longint'(1) <<< 32) - 1;
    if (md[1:0] == 2'b11) return 32'h0;
    if (!md[2]) return s[31:0];
    if (md[1:0] == 2'b10) return (s > umax) ? 32'hFFFFFFFF : s[31:0];
    if (s > smax) return 32'h7FFFFFFF;
    if (s < smin) return 32'h80000000;
    return s[31:0];
  endfunction

  // one request, checks two clocks of response
  task automatic run(input logic [2:0] md, input bit wd, input logic [W-1:0] acc,
                     input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] held;
    @(negedge clk);
    in_valid = 1'b1; wide = wd; mode = md; acc_in = acc; src_a = a; src_b = b;
    @(negedge clk);
    in_valid = 1'b0; mode = ~md; wide = ~wd; acc_in = ~acc; src_a = ~a; src_b = b ^ a;
    check(out_valid == 1'b1, "R10 valid after request", 32'(out_valid), 32'd1);
    for (int j = 0; j < LANES; j++) begin
      longint s;
      logic [31:0] exp;
      string tag;
      s = lane_sum(md, acc[j*32 +: 32], a[(2*j)*16 +: 16], a[(2*j+1)*16 +: 16],
                   b[(2*j)*16 +: 16], b[(2*j+1)*16 +: 16]);
      exp = lane_ref(md, s);
      if (!wd && j >= LANES/2) exp = 32'h0;
      if (md[1:0] == 2'b11)                     tag = "R9 unused mode";
      else if (!wd && j >= LANES/2)             tag = "R8 narrow upper lane";
      else if (md[2] && md[1:0] == 2'b10)       tag = "R7 unsigned saturate";
      else if (md[2])                           tag = "R6 signed saturate";
      else if (s != longint'(exp) && s != longint'($signed(exp))) tag = "R5 wrap";
      else if (md[1:0] == 2'b00)                tag = "R2 signed x unsigned";
      else if (md[1:0] == 2'b01)                tag = "R3 unsigned x signed";
      else                                      tag = "R4 unsigned x unsigned";
      check(result[j*32 +: 32] == exp, $sformatf("%s lane %0d mode %0d", tag, j, md),
            result[j*32 +: 32], exp);
    end
    held = result;
    @(negedge clk);
    check(out_valid == 1'b0, "R10 idle clears valid", 32'(out_valid), 32'd0);
    check(result == held, "R10 result held", result[31:0], held[31:0]);
  endtask

  logic [15:0] vals [6];
  logic [31:0] accs [7];

  initial begin
    vals = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234};
    accs = '{32'h00000000, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF,
             32'h7FFF8000, 32'h80007FFF, 32'h00010000};
    rst_n = 1'b0; in_valid = 1'b0; wide = 1'b1; mode = 3'b000;
    acc_in = '0; src_a = '0; src_b = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R11 reset state", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R11 valid low after release", 32'(out_valid), 32'd0);

    // R1: distinct per-lane values in unsigned wrapping mode
    begin
      logic [W-1:0] a, b, acc;
      for (int j = 0; j < LANES; j++) begin
        acc[j*32 +: 32]       = 32'(j);
        a[(2*j)*16 +: 16]     = 16'(j + 1);
        a[(2*j+1)*16 +: 16]   = 16'(j + 2);
        b[(2*j)*16 +: 16]     = 16'd2;
        b[(2*j+1)*16 +: 16]   = 16'd3;
      end
      @(negedge clk);
      in_valid = 1'b1; wide = 1'b1; mode = 3'b010; acc_in = acc; src_a = a; src_b = b;
      @(negedge clk);
      in_valid = 1'b0;
      for (int j = 0; j < LANES; j++)
        check(result[j*32 +: 32] == 32'(j + 2*(j+1) + 3*(j+2)),
              $sformatf("R1 lane mapping lane %0d", j),
              result[j*32 +: 32], 32'(j + 2*(j+1) + 3*(j+2)));
    end

    for (int md = 0; md < 8; md++)
      for (int wd = 0; wd < 2; wd++)
        for (int ic = 0; ic < 7; ic++)
          for (int ia = 0; ia < 6; ia++)
            for (int ib = 0; ib < 6; ib++) begin
              logic [W-1:0] a, b, acc;
              for (int j = 0; j < LANES; j++) begin
                acc[j*32 +: 32]     = accs[(ic + j) % 7];
                a[(2*j)*16 +: 16]   = vals[(ia + j) % 6];
                a[(2*j+1)*16 +: 16] = vals[(ia + 2*j + 1) % 6];
                b[(2*j)*16 +: 16]   = vals[(ib + 3*j) % 6];
                b[(2*j+1)*16 +: 16] = vals[(ib + j + 4) % 6];
              end
              run(3'(md), wd[0], acc, a, b);
            end

    // R11: reset acts without a clock edge
    @(negedge clk);
    in_valid = 1'b1; mode = 3'b000;
    @(negedge clk);
    in_valid = 1'b0;
    #1 rst_n = 1'b0;
    #0.5;
    check(out_valid == 1'b0, "R11 asynchronous clear", 32'(out_valid), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule